// File: doc/BRIEF.md
# Self-Timed Page Write Controller

This block sits behind a serial memory front end and turns a finished write transfer into one timed internal programming cycle. The front end opens a transfer with a start address, hands over data bytes one at a time, and at the end of the transfer issues a commit. The bytes are gathered in a page latch of 32 slots. The slot pointer starts at the low five bits of the address and wraps inside the page, so a long transfer overwrites its own earlier bytes. A commit that passes every gate starts a busy period whose length is a parameter in clock cycles. At the end of that period the loaded slots, and only those, are copied into a 1K x 8 array.

The same path also serves status writes. A commit marked as a status write uses the most recently loaded byte. It runs a shorter timed cycle and then updates the non-volatile fields: a write-protect enable flag and a two-bit block lock level. The block lock level decides which upper part of the array refuses array commits. While any cycle runs, the status byte reads as all ones. The block also ignores every new transfer, byte or commit. In the last busy cycle it pulses a request that the write-enable latch be cleared.

Top module: `pgw_page_writer`

## Requirements
- R1: After reset `wip` and `wel_clear` are 0, every array byte reads 0xFF, and the write-protect enable and block lock fields are 0. With `wel_in` low, `status_out` then reads 0x00.
- R2: `xfer_start` captures `xfer_addr`. Its upper five bits select the page and its lower five bits set the slot pointer. `xfer_start` also empties the latch. Each `byte_stb` stores `byte_in` at the pointer, and the pointer then advances modulo 32. A later byte for the same slot replaces the earlier one.
- R3: An accepted array commit raises `wip` in the cycle after the commit edge. `wip` then stays high for exactly WR_CYCLES clock cycles.
- R4: While `wip` is 1, `status_out` is 0xFF. When idle, `status_out` has the enable flag in bit 7, the block lock level in bits 3:2 and `wel_in` in bit 1. Bits 6:4 and bit 0 are 0.
- R5: `wel_clear` is high for exactly one cycle per completed cycle, the last cycle in which `wip` is 1, for both array and status cycles.
- R6: At the end of an array cycle, each loaded slot k is written to address page*32+k. Every other array byte keeps its value.
- R7: A commit starts no cycle if `wel_in` is 0, if no byte was loaded since the last `xfer_start` or completed cycle, or if `commit_whole` is 0.
- R8: An array commit starts no cycle when its page is locked. Lock level 0 locks nothing. Level 1 locks addresses 0x300-0x3FF. Level 2 locks 0x200-0x3FF. Level 3 locks the whole array.
- R9: A status commit (`commit_status`=1) starts a cycle only if `sr_allow` is 1. `wip` then stays high for SR_CYCLES cycles. At the end, bit 7 of the last loaded byte becomes the enable flag and bits 3:2 become the lock level.
- R10: While `wip` is 1, `xfer_start`, `byte_stb` and `commit_stb` are ignored. Once the cycle ends, a commit with no new transfer starts nothing, and the array holds only the earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Opens a transfer, captures address, empties latch |
| xfer_addr | input | 10 | Start address of the transfer |
| byte_stb | input | 1 | Loads one data byte into the page latch |
| byte_in | input | 8 | Data byte to load |
| commit_stb | input | 1 | End of transfer, requests a cycle |
| commit_status | input | 1 | 1: status write, 0: array write |
| commit_whole | input | 1 | 1 when the transfer ended on a byte boundary |
| wel_in | input | 1 | State of the write-enable latch |
| sr_allow | input | 1 | Status write permitted by the pin protection logic |
| rd_addr | input | 10 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| status_out | output | 8 | Status byte as read by the host |
| wip | output | 1 | Internal cycle in progress |
| wel_clear | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The array path is driven with three patterns. A short transfer starting mid-page tests the pointer start and checks that untouched bytes are kept. A 40-byte transfer starting four slots before the page end tests the wrap and checks that overwritten slots keep the later byte. A transfer sent while a cycle runs checks that nothing leaks into the latch or the array. Status writes are tried with and without permission, and the lock level each one sets is then probed with commits to pages just below and just above the lock boundary. The gate tests (no enable, no bytes, a partial byte) check that these rejections leave no trace, and the two cycle lengths are measured separately.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;

  typedef enum logic [0:0] {
    OP_ARRAY  = 1'b0,
    OP_STATUS = 1'b1
  } op_kind_e;

  typedef struct packed {
    logic       wp_en;
    logic [1:0] lock_lvl;
  } nv_bits_t;

  // Lock test on the top two address bits of a page (quarter index).
  function automatic logic page_locked(input logic [1:0] lock_lvl,
                                       input logic [1:0] quarter);
    case (lock_lvl)
      2'd0:    page_locked = 1'b0;
      2'd1:    page_locked = (quarter == 2'b11);
      2'd2:    page_locked = quarter[1];
      default: page_locked = 1'b1;
    endcase
  endfunction

  // Status byte presented to the host.
  function automatic logic [7:0] status_word(input logic     busy,
                                             input nv_bits_t nv,
                                             input logic     wel);
    if (busy) status_word = 8'hFF;
    else      status_word = {nv.wp_en, 3'b000, nv.lock_lvl, wel, 1'b0};
  endfunction

endpackage

// File: rtl/pgw_cycle_timer.sv
`timescale 1ns/1ps
module pgw_cycle_timer
  import pgw_pkg::*;
#(
  parameter int WR_CYCLES = 40,
  parameter int SR_CYCLES = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  op_kind_e go_kind,
  output logic     busy,
  output logic     fin,
  output op_kind_e kind
);
  localparam int MAXC = (WR_CYCLES > SR_CYCLES) ? WR_CYCLES : SR_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] remain;
  logic [CW-1:0] run_len;

  function automatic logic [CW-1:0] span_of(input op_kind_e k);
    span_of = (k == OP_ARRAY) ? CW'(WR_CYCLES - 1) : CW'(SR_CYCLES - 1);
  endfunction

  assign fin = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      kind   <= OP_ARRAY;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end else if (go) begin
      busy   <= 1'b1;
      remain <= span_of(go_kind);
      kind   <= go_kind;
    end
  end

  // Independent up-counter used only to measure each busy run.
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_len <= '0;
    else                 run_len <= run_len + 1'b1;
  end

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (run_len == span_of(kind)));
  assert_fin_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy);
  assert_rise_from_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

endmodule

// File: rtl/pgw_page_latch.sv
`timescale 1ns/1ps
module pgw_page_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int DW         = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(PAGE_BYTES)-1:0]    start_slot,
  input  logic                             drop,
  input  logic                             load,
  input  logic [DW-1:0]                    din,
  output logic [PAGE_BYTES-1:0]            mask,
  output logic [PAGE_BYTES-1:0][DW-1:0]    lanes,
  output logic [DW-1:0]                    last_byte
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [PW-1:0] ptr;

  // Pointer advance wraps inside the page (PAGE_BYTES is a power of two).
  function automatic logic [PW-1:0] next_slot(input logic [PW-1:0] p);
    next_slot = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      ptr       <= '0;
      last_byte <= '0;
    end else if (start) begin
      mask <= '0;
      ptr  <= start_slot;
    end else if (drop) begin
      mask <= '0;
    end else if (load) begin
      mask[ptr] <= 1'b1;
      ptr       <= next_slot(ptr);
      last_byte <= din;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < PAGE_BYTES; k++) begin
      if (load && !start && !drop && ptr == PW'(k)) lanes[k] <= din;
    end
  end

  assert_one_slot_per_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start) && !$past(drop)) |->
      ((($past(mask) & ~mask) == '0) && ($countones(mask ^ $past(mask)) <= 1)));

endmodule

// File: rtl/pgw_array.sv
`timescale 1ns/1ps
module pgw_array #(
  parameter int          AW         = 10,
  parameter int          DW         = 8,
  parameter int          PAGE_BYTES = 32,
  parameter logic [7:0]  ERASED     = 8'hFF
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wr_en,
  input  logic [AW-$clog2(PAGE_BYTES)-1:0]            page,
  input  logic [PAGE_BYTES-1:0]                       mask,
  input  logic [PAGE_BYTES-1:0][DW-1:0]               lanes,
  input  logic [AW-1:0]                               rd_addr,
  output logic [DW-1:0]                               rd_data
);
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= DW'(ERASED);
    end else if (wr_en) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (mask[k]) mem[{page, PW'(k)}] <= lanes[k];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  logic hit_rd;
  assign hit_rd = wr_en && mask[rd_addr[PW-1:0]] && (page == rd_addr[AW-1:PW]);

  assert_untouched_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_addr) == rd_addr && !$past(hit_rd)) |-> $stable(rd_data));

endmodule

// File: rtl/pgw_page_writer.sv
`timescale 1ns/1ps
module pgw_page_writer
  import pgw_pkg::*;
#(
  parameter int         AW         = 10,
  parameter int         DW         = 8,
  parameter int         PAGE_BYTES = 32,
  parameter int         WR_CYCLES  = 40,
  parameter int         SR_CYCLES  = 12,
  parameter logic [7:0] ERASED     = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_start,
  input  logic [AW-1:0] xfer_addr,
  input  logic          byte_stb,
  input  logic [DW-1:0] byte_in,
  input  logic          commit_stb,
  input  logic          commit_status,
  input  logic          commit_whole,
  input  logic          wel_in,
  input  logic          sr_allow,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status_out,
  output logic          wip,
  output logic          wel_clear
);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int PGW = AW - PW;

  logic                          busy, fin;
  op_kind_e                      kind;
  logic [PGW-1:0]                page_q;
  nv_bits_t                      nv_q;
  logic [PAGE_BYTES-1:0]         mask;
  logic [PAGE_BYTES-1:0][DW-1:0] lanes;
  logic [DW-1:0]                 last_byte;

  // Named internal events.
  logic start_ok, load_ok, any_loaded, lock_hit, gate_ok, commit_ok;
  logic arr_fin, sr_fin;

  assign start_ok   = xfer_start && !busy;
  assign load_ok    = byte_stb && !busy && !xfer_start;
  assign any_loaded = |mask;
  assign lock_hit   = page_locked(nv_q.lock_lvl, page_q[PGW-1 -: 2]);
  assign gate_ok    = commit_status ? sr_allow : !lock_hit;
  assign commit_ok  = commit_stb && !busy && wel_in && commit_whole &&
                      any_loaded && gate_ok;
  assign arr_fin    = fin && (kind == OP_ARRAY);
  assign sr_fin     = fin && (kind == OP_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n)        page_q <= '0;
    else if (start_ok) page_q <= xfer_addr[AW-1:PW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_q <= '0;
    end else if (sr_fin) begin
      nv_q.wp_en    <= last_byte[7];
      nv_q.lock_lvl <= last_byte[3:2];
    end
  end

  pgw_cycle_timer #(
    .WR_CYCLES (WR_CYCLES),
    .SR_CYCLES (SR_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (commit_ok),
    .go_kind (op_kind_e'(commit_status)),
    .busy    (busy),
    .fin     (fin),
    .kind    (kind)
  );

  pgw_page_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .DW         (DW)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_ok),
    .start_slot (xfer_addr[PW-1:0]),
    .drop       (fin),
    .load       (load_ok),
    .din        (byte_in),
    .mask       (mask),
    .lanes      (lanes),
    .last_byte  (last_byte)
  );

  pgw_array #(
    .AW         (AW),
    .DW         (DW),
    .PAGE_BYTES (PAGE_BYTES),
    .ERASED     (ERASED)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_fin),
    .page    (page_q),
    .mask    (mask),
    .lanes   (lanes),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign wip        = busy;
  assign wel_clear  = fin;
  assign status_out = status_word(busy, nv_q, wel_in);

  assert_start_needs_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(commit_stb && wel_in && commit_whole));
  assert_locked_page_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wip) && !$past(commit_status)) |->
      !$past(page_locked(nv_q.lock_lvl, page_q[PGW-1 -: 2])));
  assert_status_needs_allow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wip) && $past(commit_status)) |-> $past(sr_allow));
  assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !wel_clear);
  assert_page_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip) |-> $stable(page_q));
  assert_nv_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sr_fin) |-> $stable(nv_q));

endmodule

// File: tb/test_pgw_page_writer.sv
`timescale 1ns/1ps
module test_pgw_page_writer;
  localparam int WR = 40;
  localparam int SR = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start = 0, byte_stb = 0, commit_stb = 0;
  logic       commit_status = 0, commit_whole = 1, wel_in = 0, sr_allow = 1;
  logic [9:0] xfer_addr = '0, rd_addr = '0;
  logic [7:0] byte_in = '0;
  logic [7:0] rd_data, status_out;
  logic       wip, wel_clear;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgw_page_writer #(.WR_CYCLES(WR), .SR_CYCLES(SR)) i_pgw_page_writer (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .byte_stb(byte_stb), .byte_in(byte_in), .commit_stb(commit_stb),
    .commit_status(commit_status), .commit_whole(commit_whole),
    .wel_in(wel_in), .sr_allow(sr_allow), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_out(status_out), .wip(wip),
    .wel_clear(wel_clear));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_mem[1024];
  int m_lat[32];
  bit m_mask[32];
  bit m_busy, m_kind, m_wpen;
  int m_cnt, m_ptr, m_page, m_last, m_blk;

  function automatic bit m_any();
    foreach (m_mask[k]) if (m_mask[k]) return 1;
    return 0;
  endfunction

  function automatic bit m_locked(int lvl, int addr);
    if (lvl == 1) return addr >= 768;
    if (lvl == 2) return addr >= 512;
    return lvl == 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[a]) m_mem[a] = 255;
      foreach (m_mask[k]) m_mask[k] = 0;
      m_busy = 0; m_cnt = 0; m_ptr = 0; m_page = 0; m_last = 0;
      m_wpen = 0; m_blk = 0; m_kind = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        if (!m_kind) begin
          foreach (m_mask[k]) if (m_mask[k]) m_mem[m_page * 32 + k] = m_lat[k];
        end else begin
          m_wpen = (m_last >> 7) & 1;
          m_blk  = (m_last >> 2) & 3;
        end
        m_busy = 0;
        foreach (m_mask[k]) m_mask[k] = 0;
      end else m_cnt--;
    end else begin
      bit ok;
      ok = commit_stb && wel_in && commit_whole && m_any() &&
           (commit_status ? sr_allow : !m_locked(m_blk, m_page * 32));
      if (xfer_start) begin
        m_page = xfer_addr / 32; m_ptr = xfer_addr % 32;
        foreach (m_mask[k]) m_mask[k] = 0;
      end else if (byte_stb) begin
        m_lat[m_ptr] = byte_in; m_mask[m_ptr] = 1; m_last = byte_in;
        m_ptr = (m_ptr + 1) % 32;
      end
      if (ok) begin
        m_busy = 1; m_kind = commit_status;
        m_cnt = (commit_status ? SR : WR) - 1;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int st;
      st = m_busy ? 255 : ((m_wpen << 7) | (m_blk << 2) | (wel_in << 1));
      chk("R3 wip", wip, m_busy);
      chk("R5 wel_clear", wel_clear, (m_busy && m_cnt == 0));
      chk("R4 status_out", status_out, st);
      chk("R6 rd_data", rd_data, m_mem[rd_addr]);
    end
  end

  task automatic adv();
    @(posedge clk); #2;
  endtask
  task automatic open_xfer(input int a);
    xfer_start = 1; xfer_addr = 10'(a); adv(); xfer_start = 0;
  endtask
  task automatic put(input int d);
    byte_stb = 1; byte_in = 8'(d); adv(); byte_stb = 0;
  endtask
  task automatic commit(input bit st);
    commit_stb = 1; commit_status = st; adv(); commit_stb = 0; commit_status = 0;
  endtask
  task automatic run_out(output int len, output int clears);
    len = 0; clears = 0;
    while (wip) begin
      len++; if (wel_clear) clears++;
      rd_addr = rd_addr + 10'd7;
      adv();
    end
  endtask
  task automatic peek(input int a, output int v);
    rd_addr = 10'(a); #1; v = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len, clr, v;
    repeat (3) adv();
    chk("R1 reset wip", wip, 0);
    chk("R1 reset status", status_out, 0);
    peek(10'h3FF, v); chk("R1 erased byte", v, 8'hFF);
    rst_n = 1; adv();
    wel_in = 1;

    // Short transfer mid-page
    open_xfer(10'h005);
    for (int i = 0; i < 4; i++) put(8'hA0 + i);
    commit(0);
    chk("R4 busy status", status_out, 8'hFF);
    run_out(len, clr);
    chk("R3 array cycle length", len, WR);
    chk("R5 one clear pulse", clr, 1);
    peek(10'h006, v); chk("R6 loaded byte", v, 8'hA1);
    peek(10'h004, v); chk("R6 neighbour kept", v, 8'hFF);
    peek(10'h009, v); chk("R6 neighbour kept", v, 8'hFF);

    // Wrap within page with overwrite
    open_xfer(10'h03C);
    for (int i = 0; i < 40; i++) put(8'h40 + i);
    commit(0);
    run_out(len, clr);
    peek(10'h03C, v); chk("R2 wrap overwrite", v, 8'h60);
    peek(10'h023, v); chk("R2 wrap overwrite", v, 8'h67);
    peek(10'h024, v); chk("R2 single write", v, 8'h48);
    peek(10'h040, v); chk("R2 next page untouched", v, 8'hFF);

    // Gate rejections
    wel_in = 0; open_xfer(10'h100); put(8'h11); commit(0);
    chk("R7 no wel", wip, 0);
    wel_in = 1; open_xfer(10'h100); commit(0);
    chk("R7 zero bytes", wip, 0);
    put(8'h22); commit_whole = 0; commit(0); commit_whole = 1;
    chk("R7 partial byte", wip, 0);
    adv();

    // Status write denied, then allowed (wpen=1, lock level 1)
    open_xfer(0); put(8'h84); sr_allow = 0; commit(1); sr_allow = 1;
    chk("R9 denied status write", wip, 0);
    commit(1);
    run_out(len, clr);
    chk("R9 status cycle length", len, SR);
    chk("R5 clear on status cycle", clr, 1);
    chk("R9 new status fields", status_out, 8'h86);

    // Lock level 1: 0x300 locked, 0x2E0 open
    open_xfer(10'h300); put(8'h55); commit(0);
    chk("R8 locked page", wip, 0);
    adv();
    open_xfer(10'h2E0); put(8'h66); commit(0);
    chk("R8 open page", wip, 1);
    // Traffic during busy must be ignored
    open_xfer(10'h150); put(8'h77); put(8'h78); commit(0);
    run_out(len, clr);
    chk("R10 one cycle only", len, WR - 4);
    commit(0);
    chk("R10 no leftover bytes", wip, 0);
    peek(10'h150, v); chk("R10 array untouched", v, 8'hFF);
    peek(10'h2E0, v); chk("R6 open page written", v, 8'h66);
    peek(10'h300, v); chk("R8 locked byte kept", v, 8'hFF);

    repeat (4) adv();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule